// File: doc/BRIEF.md
# Map Block Clock Allocator

This block hands out second-level translation blocks to first-level table entries when a translation faults. It holds a reverse ownership table with one slot per second-level block. Each slot is either free or names the first-level entry that owns the block. A request carries the faulting first-level index. The allocator first reads that entry's recorded block number. If the reverse table still names the faulting index as the owner of that block, the allocator only sets the entry's valid bit again.

Otherwise it runs a second-chance clock over the reverse table, starting at a pointer that persists between requests:
- A free slot is taken at once.
- An owned slot whose owner's valid bit is already clear is reclaimed.
- An owned slot whose owner is still valid loses that valid bit (it is aged), and the scan moves on.

Every aged owner becomes a candidate on the next pass, so the scan always ends. The allocator then writes the block number and a set valid bit into the faulting entry, records the new owner, and pulses done with the block number.

The first-level table lives outside the block. It is reached through a read port with one cycle of latency and a separate write port. The write port can update the valid bit alone or the valid bit together with the block field. Clearing the new block's second-level entries is left to the surrounding logic.

Top module: `map_blk_clock_alloc`

## Requirements
- R1: After reset the clock pointer is at block 0, every reverse slot is free, and `busy`, `done`, `l1_rd_en` and `l1_wr_en` are low. The first request after reset is therefore granted block 0.
- R2: A fault on an index that the reverse table still records as the owner of the block held in its first-level entry returns that block. It rewrites only the valid bit (valid=1, `l1_wr_blk_en`=0), performs no scan and leaves the pointer where it was.
- R3: When the slot under the pointer is free, that block is granted without consulting any first-level entry.
- R4: When the slot under the pointer is owned and the owner's first-level valid bit reads 0, that block is reclaimed for the faulting index.
- R5: When the slot under the pointer is owned and the owner's valid bit reads 1, the owner's valid bit is written to 0 (block field untouched), and the pointer advances to the next slot.
- R6: The pointer advances by exactly one slot at a time and wraps from the last block to block 0. A scan that finds every owner valid ages all of them and, on its second pass, grants the block where it started.
- R7: A grant writes the faulting entry with valid=1 and the block number (`l1_wr_blk_en`=1), records the faulting index as owner in the reverse table, and leaves the pointer one past the granted block. A slot never returns to free except by reset.
- R8: After a reclaim the previous owner's first-level entry stays invalid. A later fault on that previous owner is not treated as a hit and goes through a fresh scan.
- R9: `busy` is high from the cycle after a request is accepted until `done` rises. `done` is a single-cycle pulse, carries the block number on `done_blk`, and coincides with the final first-level write. A request presented while `busy` is high is ignored.
- R10: First-level read data (`l1_rd_valid`, `l1_rd_blk`) is taken in the cycle after the one in which `l1_rd_en` is high.
- R11: The first-level read and write ports are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fault request, taken when idle |
| req_idx | input | L1_W | Faulting first-level index |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_blk | output | BLK_W | Block given to the faulting index |
| l1_rd_en | output | 1 | First-level read strobe |
| l1_rd_idx | output | L1_W | First-level read index |
| l1_rd_valid | input | 1 | Valid bit read back, one cycle after the strobe |
| l1_rd_blk | input | BLK_W | Block field read back, one cycle after the strobe |
| l1_wr_en | output | 1 | First-level write strobe |
| l1_wr_idx | output | L1_W | First-level write index |
| l1_wr_valid | output | 1 | Valid bit to write |
| l1_wr_blk_en | output | 1 | Also write the block field |
| l1_wr_blk | output | BLK_W | Block field to write |

## Verification
The in-line properties check the following on every cycle:
- The pointer moves only to its wrapped successor.
- Reverse slots never drop back to free.
- Reads and writes on the first-level port never overlap.
- `done` is a single-cycle pulse that matches a valid-setting write.
- Aging writes clear the valid bit without touching the block field.

Which block is chosen for a given table state can only be shown by the bench's scenarios:
- a hit versus a fresh grant;
- a reclaim that ages the owners before it;
- a re-fault by a displaced owner;
- a full pass that ages everything and returns to its start.

The bench compares the whole modelled first-level table after each request, which also shows which entries were aged.

// File: rtl/mbca_pkg.sv
package mbca_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1WAIT,
    ST_REVRD,
    ST_HITCHK,
    ST_SCAN,
    ST_OWNRD,
    ST_OWNWAIT,
    ST_AGE
  } alloc_state_t;

endpackage

// File: rtl/mbca_owner_ram.sv
module mbca_owner_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/mbca_owned_flags.sv
module mbca_owned_flags #(
  parameter int N   = 128,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [AW-1:0] qa_addr,
  output logic          qa,
  input  logic [AW-1:0] qb_addr,
  output logic          qb
);

  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst)         flags_q <= '0;
    else if (set_en) flags_q[set_addr] <= 1'b1;
  end

  assign qa = flags_q[qa_addr];
  assign qb = flags_q[qb_addr];

  // R7
  owned_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/mbca_clock_ptr.sv
module mbca_clock_ptr #(
  parameter int N   = 128,
  localparam int AW = $clog2(N),
  localparam logic [AW-1:0] LAST = AW'(N - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (step) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
  end

  assign ptr = ptr_q;

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_q == $past(ptr_q)) ||
    (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + AW'(1))));

endmodule

// File: rtl/map_blk_clock_alloc.sv
module map_blk_clock_alloc
  import mbca_pkg::*;
#(
  parameter int NUM_BLK = 128,
  parameter int L1_W    = 12,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [L1_W-1:0]  req_idx,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] done_blk,
  output logic             l1_rd_en,
  output logic [L1_W-1:0]  l1_rd_idx,
  input  logic             l1_rd_valid,
  input  logic [BLK_W-1:0] l1_rd_blk,
  output logic             l1_wr_en,
  output logic [L1_W-1:0]  l1_wr_idx,
  output logic             l1_wr_valid,
  output logic             l1_wr_blk_en,
  output logic [BLK_W-1:0] l1_wr_blk
);

  alloc_state_t     st;
  logic [L1_W-1:0]  idx_q, own_q, rd_idx_q, wr_idx_q;
  logic [BLK_W-1:0] blk_q, wr_blk_q, done_blk_q;
  logic             rd_en_q, wr_en_q, wr_valid_q, wr_blk_en_q, done_q;

  logic [BLK_W-1:0] ptr;
  logic             own_at_ptr, own_at_blk;
  logic             ram_rd_en;
  logic [BLK_W-1:0] ram_rd_addr;
  logic [L1_W-1:0]  ram_rd_data;
  logic             hit, grant, age;

  // reverse table: owner index per block, free marker kept in flags
  assign ram_rd_en   = (st == ST_REVRD) || (st == ST_SCAN);
  assign ram_rd_addr = (st == ST_REVRD) ? l1_rd_blk : ptr;

  assign hit   = (st == ST_HITCHK) && own_at_blk && (ram_rd_data == idx_q);
  assign grant = ((st == ST_SCAN) && !own_at_ptr) ||
                 ((st == ST_AGE)  && !l1_rd_valid);
  assign age   = (st == ST_AGE) && l1_rd_valid;

  mbca_owner_ram #(.DEPTH(NUM_BLK), .DW(L1_W)) u_owner (
    .clk     (clk),
    .wr_en   (grant),
    .wr_addr (ptr),
    .wr_data (idx_q),
    .rd_en   (ram_rd_en),
    .rd_addr (ram_rd_addr),
    .rd_data (ram_rd_data)
  );

  mbca_owned_flags #(.N(NUM_BLK)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_en   (grant),
    .set_addr (ptr),
    .qa_addr  (ptr),
    .qa       (own_at_ptr),
    .qb_addr  (blk_q),
    .qb       (own_at_blk)
  );

  mbca_clock_ptr #(.N(NUM_BLK)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .step (grant || age),
    .ptr  (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      idx_q       <= '0;
      own_q       <= '0;
      blk_q       <= '0;
      rd_en_q     <= 1'b0;
      rd_idx_q    <= '0;
      wr_en_q     <= 1'b0;
      wr_idx_q    <= '0;
      wr_valid_q  <= 1'b0;
      wr_blk_en_q <= 1'b0;
      wr_blk_q    <= '0;
      done_q      <= 1'b0;
      done_blk_q  <= '0;
    end else begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            idx_q    <= req_idx;
            rd_en_q  <= 1'b1;
            rd_idx_q <= req_idx;
            st       <= ST_L1WAIT;
          end
        end
        ST_L1WAIT: st <= ST_REVRD;
        ST_REVRD: begin
          blk_q <= l1_rd_blk;
          st    <= ST_HITCHK;
        end
        ST_HITCHK: begin
          if (hit) begin
            wr_en_q     <= 1'b1;
            wr_idx_q    <= idx_q;
            wr_valid_q  <= 1'b1;
            wr_blk_en_q <= 1'b0;
            wr_blk_q    <= blk_q;
            done_q      <= 1'b1;
            done_blk_q  <= blk_q;
            st          <= ST_IDLE;
          end else begin
            st <= ST_SCAN;
          end
        end
        ST_SCAN: st <= grant ? ST_IDLE : ST_OWNRD;
        ST_OWNRD: begin
          own_q    <= ram_rd_data;
          rd_en_q  <= 1'b1;
          rd_idx_q <= ram_rd_data;
          st       <= ST_OWNWAIT;
        end
        ST_OWNWAIT: st <= ST_AGE;
        ST_AGE: begin
          if (age) begin
            wr_en_q     <= 1'b1;
            wr_idx_q    <= own_q;
            wr_valid_q  <= 1'b0;
            wr_blk_en_q <= 1'b0;
            wr_blk_q    <= ptr;
            st          <= ST_SCAN;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (grant) begin
        wr_en_q     <= 1'b1;
        wr_idx_q    <= idx_q;
        wr_valid_q  <= 1'b1;
        wr_blk_en_q <= 1'b1;
        wr_blk_q    <= ptr;
        done_q      <= 1'b1;
        done_blk_q  <= ptr;
      end
    end
  end

  assign busy         = (st != ST_IDLE);
  assign done         = done_q;
  assign done_blk     = done_blk_q;
  assign l1_rd_en     = rd_en_q;
  assign l1_rd_idx    = rd_idx_q;
  assign l1_wr_en     = wr_en_q;
  assign l1_wr_idx    = wr_idx_q;
  assign l1_wr_valid  = wr_valid_q;
  assign l1_wr_blk_en = wr_blk_en_q;
  assign l1_wr_blk    = wr_blk_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  grant_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (l1_wr_en && l1_wr_valid && (l1_wr_blk == done_blk)));

  // R5
  age_write_chk: assert property (@(posedge clk) disable iff (rst)
    (l1_wr_en && !l1_wr_valid) |-> (!done && !l1_wr_blk_en));

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(l1_rd_en && l1_wr_en));

  // R10
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    l1_rd_en |=> !l1_rd_en);

endmodule

// File: tb/map_blk_clock_alloc_tb.sv
module map_blk_clock_alloc_tb;

  localparam int NB = 128;
  localparam int IW = 12;
  localparam int BW = $clog2(NB);
  localparam int NE = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [IW-1:0] req_idx = '0;
  logic          busy, done;
  logic [BW-1:0] done_blk;
  logic          l1_rd_en, l1_wr_en, l1_wr_valid, l1_wr_blk_en;
  logic [IW-1:0] l1_rd_idx, l1_wr_idx;
  logic [BW-1:0] l1_wr_blk;
  logic          l1_rd_valid;
  logic [BW-1:0] l1_rd_blk;

  map_blk_clock_alloc #(.NUM_BLK(NB), .L1_W(IW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .busy(busy), .done(done), .done_blk(done_blk),
    .l1_rd_en(l1_rd_en), .l1_rd_idx(l1_rd_idx),
    .l1_rd_valid(l1_rd_valid), .l1_rd_blk(l1_rd_blk),
    .l1_wr_en(l1_wr_en), .l1_wr_idx(l1_wr_idx), .l1_wr_valid(l1_wr_valid),
    .l1_wr_blk_en(l1_wr_blk_en), .l1_wr_blk(l1_wr_blk)
  );

  // first-level table model: one-cycle read latency, plus bench poke port
  logic          tv [NE];
  logic [BW-1:0] tb_blk [NE];
  logic          poke_en = 1'b0;
  logic [IW-1:0] poke_idx = '0;
  logic          poke_val = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NE; i++) begin tv[i] <= 1'b0; tb_blk[i] <= '0; end
      l1_rd_valid <= 1'b0;
      l1_rd_blk   <= '0;
    end else begin
      if (l1_wr_en) begin
        tv[l1_wr_idx] <= l1_wr_valid;
        if (l1_wr_blk_en) tb_blk[l1_wr_idx] <= l1_wr_blk;
      end
      if (poke_en) tv[poke_idx] <= poke_val;
      if (l1_rd_en) begin
        l1_rd_valid <= tv[l1_rd_idx];
        l1_rd_blk   <= tb_blk[l1_rd_idx];
      end
    end
  end

  // reference allocator state
  logic          ev [NE];
  logic [BW-1:0] eb [NE];
  logic          rm_own [NB];
  int            rm_idx [NB];
  int            rm_ptr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic predict(input int idx, output int blk);
    int b;
    for (int i = 0; i < NE; i++) begin ev[i] = tv[i]; eb[i] = tb_blk[i]; end
    b = int'(eb[idx]);
    if (rm_own[b] && rm_idx[b] == idx) begin
      ev[idx] = 1'b1;
      blk = b;
      return;
    end
    forever begin
      if (!rm_own[rm_ptr] || !ev[rm_idx[rm_ptr]]) break;
      ev[rm_idx[rm_ptr]] = 1'b0;
      rm_ptr = (rm_ptr + 1) % NB;
    end
    blk = rm_ptr;
    ev[idx] = 1'b1;
    eb[idx] = BW'(rm_ptr);
    rm_own[rm_ptr] = 1'b1;
    rm_idx[rm_ptr] = idx;
    rm_ptr = (rm_ptr + 1) % NB;
  endtask

  task automatic poke(input int idx, input bit val);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = IW'(idx); poke_val = val;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic do_req(input int idx, input string req, input bit inject);
    int exp_blk;
    int n;
    int bad;
    predict(idx, exp_blk);
    @(negedge clk);
    req_valid = 1'b1; req_idx = IW'(idx);
    @(negedge clk);
    if (inject) begin
      check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
      req_idx = IW'(77);
      @(negedge clk);
    end
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check(done == 1'b1, req, "done seen", int'(done), 1);
    check(int'(done_blk) == exp_blk, req, "granted block", int'(done_blk), exp_blk);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single pulse", int'(done), 0);
    bad = -1;
    for (int i = 0; i < NE; i++)
      if (tv[i] !== ev[i] || tb_blk[i] !== eb[i]) begin bad = i; break; end
    check(bad < 0, req, "first-level table entry mismatch at index",
          bad, -1);
  endtask

  task automatic t_reset();
    check(!busy && !done && !l1_rd_en && !l1_wr_en, "R1", "idle after reset",
          int'({busy, done, l1_rd_en, l1_wr_en}), 0);
  endtask

  task automatic t_first();
    do_req(5, "R1", 1'b0);
    do_req(9, "R3", 1'b0);
    do_req(100, "R7", 1'b1);
    check(tv[77] == 1'b0, "R9", "ignored request left entry 77", int'(tv[77]), 0);
  endtask

  task automatic t_hit();
    poke(9, 1'b0);
    do_req(9, "R2", 1'b0);
    check(tb_blk[9] == BW'(1), "R2", "hit keeps block", int'(tb_blk[9]), 1);
    do_req(300, "R2", 1'b0);
    check(tb_blk[300] == BW'(3), "R2", "pointer unchanged by hit", int'(tb_blk[300]), 3);
  endtask

  task automatic t_fill();
    for (int k = 4; k < NB; k++) do_req(1000 + k, "R7", 1'b0);
    check(rm_ptr == 0, "R6", "pointer wrapped", rm_ptr, 0);
  endtask

  task automatic t_reclaim();
    poke(100, 1'b0);
    do_req(2000, "R4", 1'b0);
    check(tb_blk[2000] == BW'(2), "R4", "reclaimed block", int'(tb_blk[2000]), 2);
    check(tv[5] == 1'b0 && tv[9] == 1'b0, "R5", "owners aged",
          int'({tv[5], tv[9]}), 0);
    check(tv[100] == 1'b0, "R8", "old owner stays invalid", int'(tv[100]), 0);
    do_req(100, "R8", 1'b0);
    check(tb_blk[100] == BW'(0), "R8", "re-fault scanned to block", int'(tb_blk[100]), 0);
  endtask

  task automatic t_fullpass();
    int start;
    for (int b = 0; b < NB; b++) poke(rm_idx[b], 1'b1);
    start = rm_ptr;
    do_req(3000, "R6", 1'b0);
    check(int'(tb_blk[3000]) == start, "R6", "full pass returns to start",
          int'(tb_blk[3000]), start);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin rm_own[b] = 1'b0; rm_idx[b] = 0; end
    rm_ptr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first();
    t_hit();
    t_fill();
    t_reclaim();
    t_fullpass();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule